// File: doc/BRIEF.md
# Stereo Serial-Audio Receive Channel

This block takes in one stereo serial-audio stream in the standard I2S format: a bit clock, a word-select line and a serial data line. It turns that stream into left/right sample pairs. The three serial inputs are oversampled in the system clock domain. Data bits are taken on rising edges of the bit clock, and a change of the word-select level marks the end of a word. Each completed pair goes into a small FIFO, and software drains it through two holding registers.

Software controls the channel through a simple register port. The port gives software:
- three enable gates, all of which must be on before anything is captured;
- a word resolution code;
- a FIFO trigger level that drives a "data available" status;
- a sticky overrun status, cleared by a read of its own register;
- a mask for each status source;
- a FIFO flush.

A single interrupt output is the OR of the status sources that are not masked.

Top module: `i2s_rx_chan`

## Requirements
- R1: After reset the status register (0x38) reads 0, the mask register (0x3C) reads 3, the trigger register (0x48) reads 0, the resolution register (0x30) reads 2, `irq` is low and the left holding register reads 0.
- R2: A read strobe at a byte address returns the data on `bus_rdata` one clock later. The map is: global enable 0x00 bit 0, receiver enable 0x04 bit 0, left data 0x20, right data 0x24, channel enable 0x28 bit 0, resolution code 0x30 bits 2:0, status 0x38, mask 0x3C bits 1:0, overrun clear 0x40, trigger level 0x48 bits 3:0, flush 0x50 bit 0.
- R3: Bits are taken on rising bit-clock edges, MSB first. A word starts one bit after a word-select change: low selects left and high selects right. The last bit of a word is the one sampled at the edge where word-select is first seen changed. A pair is pushed when its right word completes, and only if a left word completed before it.
- R4: Resolution code 2 keeps 16 bits, code 4 keeps 24 bits and code 5 keeps 32 bits. Code 1 keeps 12 bits, code 3 keeps 20 bits, and codes 0, 6 and 7 keep 32 bits. The first bits of each word up to the resolution are kept right-justified. Later bits of the slot are ignored, and the unused upper bits read 0.
- R5: Capture happens only while the global enable, the receiver enable and the channel enable are all 1. While any of them is 0 the framing state is discarded. After enabling, the first word-select change only aligns the receiver, and the word that ends there is not kept.
- R6: The FIFO holds 16 pairs in arrival order. Reading 0x20 returns the oldest left word. Reading 0x24 returns the oldest right word and removes the pair. When the FIFO is empty, both registers read 0.
- R7: A pair that completes while the FIFO is full is dropped. Status bit 1 (overrun) is then set, and the FIFO contents stay unchanged.
- R8: A read of 0x40 returns 0 and clears the overrun status.
- R9: Status bit 0 (data available) is 1 exactly when the FIFO holds more pairs than the trigger level.
- R10: `irq` is the OR of status bits whose mask bit is 0. Mask bit 0 covers data available and mask bit 1 covers overrun, and a 1 in a mask bit masks that source.
- R11: Writing 1 to bit 0 of 0x50 empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (9) | Byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid one clock after the strobe |
| sck | input | 1 | Serial bit clock |
| ws | input | 1 | Word select (low = left) |
| sd | input | 1 | Serial data |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
A read result is due on `bus_rdata` on the edge that takes the strobe. That edge also pops the FIFO and clears the overrun status, so status and `irq` show the change from the following cycle. The bench strobes on one falling edge and samples on the next. Serial bits need three clocks to pass the oversampling flops and the edge detector. The bench holds each bit-clock level for four clocks and waits several clocks after a stream ends before it reads status. That way every push has landed before status, `irq` or the FIFO is sampled.

// File: rtl/i2s_rx_chan.sv
module i2s_rx_chan #(
  parameter int DEPTH = 16,
  parameter int AW    = 9,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sck,
  input  logic          ws,
  input  logic          sd,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int BW = $clog2(DW + 1);
  localparam logic [AW-1:0] A_GEN   = AW'('h00);
  localparam logic [AW-1:0] A_RXEN  = AW'('h04);
  localparam logic [AW-1:0] A_LEFT  = AW'('h20);
  localparam logic [AW-1:0] A_RIGHT = AW'('h24);
  localparam logic [AW-1:0] A_CHEN  = AW'('h28);
  localparam logic [AW-1:0] A_RES   = AW'('h30);
  localparam logic [AW-1:0] A_STAT  = AW'('h38);
  localparam logic [AW-1:0] A_MASK  = AW'('h3C);
  localparam logic [AW-1:0] A_OVCLR = AW'('h40);
  localparam logic [AW-1:0] A_TRIG  = AW'('h48);
  localparam logic [AW-1:0] A_FLUSH = AW'('h50);

  logic          glb_en, rx_en, ch_en, ovr;
  logic [2:0]    res_code;
  logic [1:0]    mask;
  logic [PW-1:0] trig;
  logic [CW-1:0] count;
  logic [PW-1:0] wp, rp;
  logic [2*DW-1:0] mem [DEPTH];

  wire cap_en = glb_en & rx_en & ch_en;
  wire wr_stb = bus_sel & bus_wr;
  wire rd_stb = bus_sel & ~bus_wr;
  wire empty  = (count == '0);
  wire full   = (count == CW'(DEPTH));
  wire flush  = wr_stb && bus_addr == A_FLUSH && bus_wdata[0];
  wire pop    = rd_stb && bus_addr == A_RIGHT && !empty;
  wire ovr_clr = rd_stb && bus_addr == A_OVCLR;
  wire unused_wd = ^bus_wdata[DW-1:PW];

  // serial front end, oversampled
  logic [2:0] sck_p;
  logic [1:0] ws_p, sd_p;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_p <= '0; ws_p <= '0; sd_p <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sck};
      ws_p  <= {ws_p[0], ws};
      sd_p  <= {sd_p[0], sd};
    end
  end
  wire rise = sck_p[1] & ~sck_p[2];
  wire ws_s = ws_p[1];
  wire sd_s = sd_p[1];

  function automatic logic [BW-1:0] res_len(input logic [2:0] c);
    case (c)
      3'd1:    res_len = BW'(12);
      3'd2:    res_len = BW'(16);
      3'd3:    res_len = BW'(20);
      3'd4:    res_len = BW'(24);
      default: res_len = BW'(DW);
    endcase
  endfunction

  logic          ws_last, synced, have_left;
  logic [BW-1:0] bcnt;
  logic [DW-1:0] sh, left_w;
  wire [BW-1:0] rlen   = res_len(res_code);
  wire          take   = bcnt < rlen;
  wire [DW-1:0] bit_sh = take ? {sh[DW-2:0], sd_s} : sh;
  wire          ws_chg = ws_s != ws_last;
  wire push_req = rise & cap_en & ws_chg & synced & ws_last & have_left;
  wire push     = push_req & ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) ws_last <= 1'b0;
    else if (rise) ws_last <= ws_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !cap_en) begin
      synced <= 1'b0; have_left <= 1'b0; bcnt <= '0; sh <= '0; left_w <= '0;
    end else if (rise) begin
      if (ws_chg) begin
        synced <= 1'b1;
        sh     <= '0;
        bcnt   <= '0;
        if (synced) begin
          if (!ws_last) begin
            left_w    <= bit_sh;
            have_left <= 1'b1;
          end else begin
            have_left <= 1'b0;
          end
        end
      end else begin
        sh   <= bit_sh;
        bcnt <= bcnt + BW'(take);
      end
    end
  end

  // pair FIFO
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {left_w, bit_sh};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  wire [2*DW-1:0] head  = empty ? '0 : mem[rp];
  wire            avail = count > {1'b0, trig};

  always_ff @(posedge clk) begin
    if (!rst_n) ovr <= 1'b0;
    else if (push_req && full) ovr <= 1'b1;
    else if (ovr_clr) ovr <= 1'b0;
  end

  assign irq = |({ovr, avail} & ~mask);

  // register port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en <= 1'b0; rx_en <= 1'b0; ch_en <= 1'b0;
      res_code <= 3'd2; mask <= 2'b11; trig <= '0;
    end else if (wr_stb) begin
      case (bus_addr)
        A_GEN:  glb_en   <= bus_wdata[0];
        A_RXEN: rx_en    <= bus_wdata[0];
        A_CHEN: ch_en    <= bus_wdata[0];
        A_RES:  res_code <= bus_wdata[2:0];
        A_MASK: mask     <= bus_wdata[1:0];
        A_TRIG: trig     <= bus_wdata[PW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_stb) begin
      case (bus_addr)
        A_GEN:   bus_rdata <= DW'(glb_en);
        A_RXEN:  bus_rdata <= DW'(rx_en);
        A_LEFT:  bus_rdata <= head[2*DW-1:DW];
        A_RIGHT: bus_rdata <= head[DW-1:0];
        A_CHEN:  bus_rdata <= DW'(ch_en);
        A_RES:   bus_rdata <= DW'(res_code);
        A_STAT:  bus_rdata <= DW'({ovr, avail});
        A_MASK:  bus_rdata <= DW'(mask);
        A_TRIG:  bus_rdata <= DW'(trig);
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/i2s_rx_chan_chk.sv
module i2s_rx_chan_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic          ovr,
  input logic          cap_en,
  input logic          flush,
  input logic          pop,
  input logic          push_req,
  input logic          ovr_clr,
  input logic [1:0]    mask,
  input logic          irq
);
  a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r7_ovr_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(count) == CW'(DEPTH));

  a_r7_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !flush && !pop) |=> count == CW'(DEPTH));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !(push_req && count == CW'(DEPTH))) |=> !ovr);

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);

  a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> count <= $past(count));

  a_r10_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    mask == 2'b11 |-> !irq);
endmodule

bind i2s_rx_chan i2s_rx_chan_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .count(count), .ovr(ovr), .cap_en(cap_en),
  .flush(flush), .pop(pop), .push_req(push_req), .ovr_clr(ovr_clr),
  .mask(mask), .irq(irq)
);

// File: tb/i2s_rx_chan_tb_top.sv
module i2s_rx_chan_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic irq;
  int vecs = 0, errs = 0;
  bit done = 1'b0;
  bit chq[$];
  bit dq[$];

  always #2.5 clk = ~clk;

  i2s_rx_chan dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .ws(ws), .sd(sd), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FIFO-RX FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  function automatic logic [31:0] lval(input int s, input int i);
    return 32'((s * 7 + i + 1) * 32'h9E3779B1) ^ 32'hA5C3_0F69;
  endfunction
  function automatic logic [31:0] rval(input int s, input int i);
    return ~lval(s + 13, i) ^ 32'h1234_8765;
  endfunction
  function automatic logic [31:0] expw(input logic [31:0] v, input int slot, input int res);
    logic [63:0] t;
    t = 64'(v) & ((64'd1 << slot) - 1);
    t = t >> (slot - res);
    return 32'(t & ((64'd1 << res) - 1));
  endfunction

  task automatic add_word(input bit ch, input logic [31:0] v, input int slot);
    for (int b = slot - 1; b >= 0; b--) begin
      chq.push_back(ch); dq.push_back(v[b]);
    end
  endtask

  task automatic send(input int nf, input int slot, input int seed, input bit restart);
    if (restart) begin wr(9'h28, 0); wr(9'h28, 1); end
    add_word(1'b1, 32'hFFFF_FFFF, slot);
    for (int i = 0; i < nf; i++) begin
      add_word(1'b0, lval(seed, i), slot);
      add_word(1'b1, rval(seed, i), slot);
    end
    chq.push_back(1'b0); dq.push_back(1'b0);
    for (int n = 0; n < chq.size(); n++) begin
      @(negedge clk);
      ws = (n + 1 < chq.size()) ? chq[n+1] : chq[n];
      sd = dq[n]; sck = 1'b0;
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (3) @(negedge clk);
    end
    @(negedge clk); sck = 1'b0;
    repeat (8) @(negedge clk);
    chq.delete(); dq.delete();
  endtask

  task automatic drain(input int nf, input int slot, input int res, input int seed, input string req);
    logic [31:0] d;
    for (int i = 0; i < nf; i++) begin
      rd(9'h20, d); chk(req, d, expw(lval(seed, i), slot, res));
      rd(9'h24, d); chk(req, d, expw(rval(seed, i), slot, res));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errs++;
      $display("FIFO-RX FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int codes[5] = '{2, 2, 4, 5, 1};
    int slots[5] = '{16, 32, 32, 32, 16};
    int ress[5]  = '{16, 16, 24, 32, 12};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(9'h38, d); chk("R1 status", d, 0);
    rd(9'h3C, d); chk("R1 mask", d, 3);
    rd(9'h48, d); chk("R1 trigger", d, 0);
    rd(9'h30, d); chk("R1 resolution", d, 2);
    chk("R1 irq", 32'(irq), 0);
    rd(9'h20, d); chk("R1 R6 empty left", d, 0);

    wr(9'h00, 1); wr(9'h04, 1); wr(9'h3C, 0);
    rd(9'h00, d); chk("R2 global enable readback", d, 1);

    // R3 R4 resolution / slot sweep
    for (int k = 0; k < 5; k++) begin
      wr(9'h30, 32'(codes[k]));
      send(3, slots[k], k, 1);
      rd(9'h38, d); chk("R9 available", d, 1);
      chk("R10 irq on available", 32'(irq), 1);
      drain(3, slots[k], ress[k], k, "R3 R4 word");
      rd(9'h38, d); chk("R6 drained", d, 0);
      chk("R10 irq idle", 32'(irq), 0);
      rd(9'h24, d); chk("R6 empty right", d, 0);
    end

    // R9 trigger threshold
    wr(9'h30, 2);
    for (int t = 3; t <= 7; t += 4) begin
      wr(9'h48, 32'(t));
      send(t, 16, 20 + t, 1);
      rd(9'h38, d); chk("R9 at threshold", d, 0);
      send(1, 16, 40, 1);
      rd(9'h38, d); chk("R9 above threshold", d, 1);
      wr(9'h50, 1);
      rd(9'h38, d); chk("R11 flushed status", d, 0);
      rd(9'h20, d); chk("R11 flushed data", d, 0);
    end
    wr(9'h48, 0);

    // R10 masking
    send(1, 16, 50, 1);
    wr(9'h3C, 1); @(negedge clk); chk("R10 avail masked", 32'(irq), 0);
    wr(9'h3C, 2); @(negedge clk); chk("R10 avail unmasked", 32'(irq), 1);
    wr(9'h3C, 3); @(negedge clk); chk("R10 all masked", 32'(irq), 0);
    wr(9'h50, 1);

    // R7 R8 overrun
    wr(9'h3C, 1);
    send(17, 16, 60, 1);
    rd(9'h38, d); chk("R7 overrun status", d, 3);
    chk("R10 irq on overrun", 32'(irq), 1);
    rd(9'h40, d); chk("R8 clear reads zero", d, 0);
    rd(9'h38, d); chk("R8 overrun cleared", d, 1);
    chk("R8 irq released", 32'(irq), 0);
    drain(16, 16, 16, 60, "R7 kept entries");
    rd(9'h38, d); chk("R7 extra pair dropped", d, 0);
    wr(9'h3C, 0);

    // R5 enable gating
    wr(9'h00, 0); send(2, 16, 70, 1);
    rd(9'h38, d); chk("R5 global off", d, 0);
    wr(9'h00, 1); wr(9'h04, 0); send(2, 16, 71, 1);
    rd(9'h38, d); chk("R5 receiver off", d, 0);
    wr(9'h04, 1); wr(9'h28, 0); send(2, 16, 72, 0);
    rd(9'h38, d); chk("R5 channel off", d, 0);
    rd(9'h20, d); chk("R5 nothing stored", d, 0);
    send(2, 16, 73, 1);
    drain(2, 16, 16, 73, "R5 all on");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule